// File: doc/BRIEF.md
# Shifter Operand Unit with Carry-Out

This block prepares the second operand of a 32-bit data-processing datapath. It shifts or rotates a data word by a chosen amount and returns both the shifted word and the carry bit that the shift pushes out. The caller supplies the word, a 2-bit shift kind, an amount, a flag that picks where the amount comes from, and the present carry flag.

In immediate form, only the low five bits of the amount input count. A zero in those bits is an escape code whose meaning depends on the shift kind. In register form, all eight bits count, so the amount can be 0 to 255. A zero amount then leaves the word and the carry untouched, and amounts of 32 and above saturate in a way set by the shift kind. The block is purely combinational. It holds no state and has no clock or reset.

Top module: `sh_operand_shifter`

## Requirements
- R1: Shift kind code 0 is logical left. In immediate form, an amount n from 1 to 31 gives operand<<n with carry-out = operand[32-n]. A zero amount returns the operand unchanged with carry-out = carry_i.
- R2: Shift kind code 1 is logical right. In immediate form, n from 1 to 31 gives operand>>n with carry-out = operand[n-1]. A zero amount means a shift by 32: the result is 0 and the carry-out is operand[31].
- R3: Shift kind code 2 is arithmetic right. In immediate form, n from 1 to 31 sign-fills, with carry-out = operand[n-1]. A zero amount means a shift by 32: every result bit is operand[31] and the carry-out is operand[31].
- R4: Shift kind code 3 is rotate right. In immediate form, n from 1 to 31 rotates right by n with carry-out = operand[n-1].
- R5: In immediate form, rotate right with a zero amount is a one-bit rotate through carry. The result is {carry_i, operand[31:1]} and the carry-out is operand[0].
- R6: In register form (reg_mode_i=1), an amount of 0 returns the operand unchanged with carry-out = carry_i, for all four shift kinds.
- R7: In register form, logical left and logical right by 1 to 31 behave as in R1 and R2. By exactly 32 the result is 0, and the carry-out is operand[0] for left and operand[31] for right.
- R8: In register form, logical left and logical right by 33 to 255 give result 0 and carry-out 0.
- R9: In register form, arithmetic right by 32 or more fills every result bit with operand[31] and gives carry-out = operand[31]. Below 32 it behaves as in R3.
- R10: In register form, rotate right uses the amount modulo 32. A nonzero amount whose low five bits are zero returns the operand unchanged with carry-out = operand[31].
- R11: In immediate form, amount bits [7:5] have no effect on the result or the carry-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 32 | Word to shift |
| type_i | input | 2 | Shift kind: 0 left, 1 right logical, 2 right arithmetic, 3 rotate right |
| reg_mode_i | input | 1 | 0: immediate amount (bits [4:0]); 1: register amount (bits [7:0]) |
| amt_i | input | 8 | Shift amount |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted word |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The assertions run on every evaluation. They check that a register-form zero amount passes the word and the carry through, that the one-bit rotate through carry takes its new top bit from the carry flag and gives out bit 0, that an oversized logical shift leaves nothing behind, that a saturated arithmetic shift is a pure sign fill, and that every rotate keeps the count of set bits. Exact bit positions come only from the bench scenarios, which compare against an independent model at amounts 0, 1, 31, 32, 33 and 255. These include the carry-out index for each shift kind, the escape meaning of a zero immediate amount, and the fact that the unused immediate amount bits are ignored.

// File: rtl/sh_pkg.sv
package sh_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } sh_type_e;
endpackage

// File: rtl/sh_amt_decode.sv
// Folds mode and escape codes into one effective amount plus bypass flags.
module sh_amt_decode
  import sh_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8,
  localparam int IMM_W = $clog2(W),
  localparam int SA_W  = IMM_W + 1
) (
  input  sh_type_e          type_i,
  input  logic              reg_mode_i,
  input  logic [AMT_W-1:0]  amt_i,
  output logic              pass_o,
  output logic              rrx_o,
  output logic [SA_W-1:0]   sa_o,
  output logic              over_o
);
  localparam logic [AMT_W-1:0] W_AMT = AMT_W'(W);

  logic [IMM_W-1:0] imm;
  logic             imm_zero;
  logic [AMT_W-1:0] eff;

  always_comb begin
    imm      = amt_i[IMM_W-1:0];
    imm_zero = (imm == '0);
    pass_o   = 1'b0;
    rrx_o    = 1'b0;
    if (!reg_mode_i) begin
      pass_o = (type_i == SH_LSL) && imm_zero;
      rrx_o  = (type_i == SH_ROR) && imm_zero;
      eff    = imm_zero ? W_AMT : AMT_W'(imm);
    end else begin
      pass_o = (amt_i == '0);
      // rotate folds modulo W; a folded zero means a full turn
      if (type_i == SH_ROR) eff = imm_zero ? W_AMT : AMT_W'(imm);
      else                  eff = amt_i;
    end
    over_o = (eff > W_AMT);
    sa_o   = over_o ? SA_W'(W) : eff[SA_W-1:0];
  end
endmodule

// File: rtl/sh_core.sv
// Shift by sa in 1..W; over_i flags an amount beyond W.
module sh_core
  import sh_pkg::*;
#(
  parameter int W = 32,
  localparam int SA_W = $clog2(W) + 1
) (
  input  logic [W-1:0]    op_i,
  input  sh_type_e        type_i,
  input  logic [SA_W-1:0] sa_i,
  input  logic            over_i,
  output logic [W-1:0]    res_o,
  output logic            c_o
);
  logic        [2*W-1:0] lw, rw, rot;
  logic signed [2*W-1:0] aw;

  always_comb begin
    // last bit shifted out lands just past the result window
    lw  = {{W{1'b0}}, op_i} << sa_i;
    rw  = {op_i, {W{1'b0}}} >> sa_i;
    aw  = $signed({op_i, {W{1'b0}}}) >>> sa_i;
    rot = {op_i, op_i} >> sa_i;
    unique case (type_i)
      SH_LSL: begin
        res_o = over_i ? '0 : lw[W-1:0];
        c_o   = over_i ? 1'b0 : lw[W];
      end
      SH_LSR: begin
        res_o = over_i ? '0 : rw[2*W-1:W];
        c_o   = over_i ? 1'b0 : rw[W-1];
      end
      SH_ASR: begin
        res_o = aw[2*W-1:W];
        c_o   = aw[W-1];
      end
      default: begin
        res_o = rot[W-1:0];
        c_o   = rot[W-1];
      end
    endcase
  end
endmodule

// File: rtl/sh_operand_shifter.sv
module sh_operand_shifter
  import sh_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 8,
  localparam int SA_W = $clog2(W) + 1
) (
  input  logic [W-1:0]     operand_i,
  input  logic [1:0]       type_i,
  input  logic             reg_mode_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             carry_i,
  output logic [W-1:0]     result_o,
  output logic             carry_o
);
  sh_type_e        ty;
  logic            pass, rrx, over, core_c;
  logic [SA_W-1:0] sa;
  logic [W-1:0]    core_res;

  assign ty = sh_type_e'(type_i);

  sh_amt_decode #(.W(W), .AMT_W(AMT_W)) u_dec (
    .type_i(ty), .reg_mode_i(reg_mode_i), .amt_i(amt_i),
    .pass_o(pass), .rrx_o(rrx), .sa_o(sa), .over_o(over)
  );

  sh_core #(.W(W)) u_core (
    .op_i(operand_i), .type_i(ty), .sa_i(sa), .over_i(over),
    .res_o(core_res), .c_o(core_c)
  );

  always_comb begin
    if (pass) begin
      result_o = operand_i;
      carry_o  = carry_i;
    end else if (rrx) begin
      result_o = {carry_i, operand_i[W-1:1]};
      carry_o  = operand_i[0];
    end else begin
      result_o = core_res;
      carry_o  = core_c;
    end
  end

  localparam logic [AMT_W-1:0] W_AMT = AMT_W'(W);

  always_comb begin
    if (reg_mode_i && amt_i == '0)
      p_reg_zero_pass_r6: assert (result_o == operand_i && carry_o == carry_i);
    if (!reg_mode_i && ty == SH_ROR && amt_i[SA_W-2:0] == '0)
      p_rrx_through_carry_r5: assert (result_o[W-1] == carry_i && carry_o == operand_i[0]);
    if (reg_mode_i && (ty == SH_LSL || ty == SH_LSR) && amt_i > W_AMT)
      p_big_logical_clear_r8: assert (result_o == '0 && !carry_o);
    if (reg_mode_i && ty == SH_ASR && amt_i >= W_AMT)
      p_asr_sign_fill_r9: assert (($countones(result_o) == 0 || $countones(result_o) == W)
                                  && carry_o == result_o[W-1]);
    if (ty == SH_ROR && (reg_mode_i || amt_i[SA_W-2:0] != '0))
      p_rotate_keeps_ones_r10: assert ($countones(result_o) == $countones(operand_i));
  end
endmodule

// File: tb/tb_sh_operand_shifter.sv
module tb_sh_operand_shifter;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [31:0] operand_i, result_o;
  logic [1:0]  type_i;
  logic        reg_mode_i, carry_i, carry_o;
  logic [7:0]  amt_i;

  sh_operand_shifter dut (
    .operand_i(operand_i), .type_i(type_i), .reg_mode_i(reg_mode_i),
    .amt_i(amt_i), .carry_i(carry_i), .result_o(result_o), .carry_o(carry_o)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic [31:0] op;
    logic [1:0]  ty;
    logic        md;
    logic [7:0]  amt;
    logic        ci;
    logic [31:0] res;
    logic        co;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{32'h8000_0001, 2'd0, 1'b0, 8'd1,   1'b0, 32'h0000_0002, 1'b1, 4'd1},  // R1
    '{32'h8000_0001, 2'd0, 1'b0, 8'd0,   1'b1, 32'h8000_0001, 1'b1, 4'd1},  // R1
    '{32'h8000_0001, 2'd1, 1'b0, 8'd0,   1'b0, 32'h0000_0000, 1'b1, 4'd2},  // R2
    '{32'h0000_0006, 2'd1, 1'b0, 8'd2,   1'b0, 32'h0000_0001, 1'b1, 4'd2},  // R2
    '{32'h8000_0000, 2'd2, 1'b0, 8'd0,   1'b0, 32'hFFFF_FFFF, 1'b1, 4'd3},  // R3
    '{32'h8000_0004, 2'd2, 1'b0, 8'd3,   1'b0, 32'hF000_0000, 1'b1, 4'd3},  // R3
    '{32'h0000_0003, 2'd3, 1'b0, 8'd1,   1'b0, 32'h8000_0001, 1'b1, 4'd4},  // R4
    '{32'h0000_0003, 2'd3, 1'b0, 8'd0,   1'b0, 32'h0000_0001, 1'b1, 4'd5},  // R5
    '{32'h0000_0002, 2'd3, 1'b0, 8'd0,   1'b1, 32'h8000_0001, 1'b0, 4'd5},  // R5
    '{32'h1234_5678, 2'd2, 1'b1, 8'd0,   1'b1, 32'h1234_5678, 1'b1, 4'd6},  // R6
    '{32'h0000_0001, 2'd0, 1'b1, 8'd32,  1'b0, 32'h0000_0000, 1'b1, 4'd7},  // R7
    '{32'h8000_0000, 2'd1, 1'b1, 8'd32,  1'b0, 32'h0000_0000, 1'b1, 4'd7},  // R7
    '{32'hFFFF_FFFF, 2'd0, 1'b1, 8'd33,  1'b1, 32'h0000_0000, 1'b0, 4'd8},  // R8
    '{32'hFFFF_FFFF, 2'd1, 1'b1, 8'd255, 1'b1, 32'h0000_0000, 1'b0, 4'd8},  // R8
    '{32'h7FFF_FFFF, 2'd2, 1'b1, 8'd200, 1'b1, 32'h0000_0000, 1'b0, 4'd9},  // R9
    '{32'h8000_0000, 2'd2, 1'b1, 8'd33,  1'b0, 32'hFFFF_FFFF, 1'b1, 4'd9},  // R9
    '{32'h8000_0001, 2'd3, 1'b1, 8'd64,  1'b0, 32'h8000_0001, 1'b1, 4'd10}, // R10
    '{32'h0000_0003, 2'd3, 1'b1, 8'd33,  1'b0, 32'h8000_0001, 1'b1, 4'd10}, // R10
    '{32'h0000_0006, 2'd1, 1'b0, 8'hE2,  1'b0, 32'h0000_0001, 1'b1, 4'd11}  // R11
  };

  // independent reference, written straight from the requirements
  function automatic logic [32:0] ref_shift(input logic [31:0] op, input logic [1:0] ty,
                                            input logic md, input logic [7:0] amt,
                                            input logic ci);
    int n;
    logic [31:0] r;
    logic c;
    n = md ? int'(amt) : int'(amt[4:0]);
    if (md && n == 0) return {op, ci};
    case (ty)
      2'd0: if (n == 0) begin r = op; c = ci; end
            else if (n < 32) begin r = op << n; c = op[32-n]; end
            else if (n == 32) begin r = '0; c = op[0]; end
            else begin r = '0; c = 1'b0; end
      2'd1: if (n == 0 || n == 32) begin r = '0; c = op[31]; end
            else if (n < 32) begin r = op >> n; c = op[n-1]; end
            else begin r = '0; c = 1'b0; end
      2'd2: if (n == 0 || n >= 32) begin r = {32{op[31]}}; c = op[31]; end
            else begin
              r = op;
              for (int k = 0; k < n; k++) r = {op[31], r[31:1]};
              c = op[n-1];
            end
      default: begin
        if (!md && n == 0) begin r = {ci, op[31:1]}; c = op[0]; end
        else begin
          n = n % 32;
          if (n == 0) begin r = op; c = op[31]; end
          else begin
            r = op;
            for (int k = 0; k < n; k++) r = {r[0], r[31:1]};
            c = op[n-1];
          end
        end
      end
    endcase
    return {r, c};
  endfunction

  function automatic int req_of(input logic [1:0] ty, input logic md, input logic [7:0] amt);
    int n;
    n = md ? int'(amt) : int'(amt[4:0]);
    if (!md) begin
      if (ty == 2'd3) return (n == 0) ? 5 : 4;
      return int'(ty) + 1;
    end
    if (n == 0) return 6;
    if (ty == 2'd3) return 10;
    if (ty == 2'd2) return (n >= 32) ? 9 : 3;
    return (n > 32) ? 8 : 7;
  endfunction

  task automatic apply_check(input logic [31:0] op, input logic [1:0] ty, input logic md,
                             input logic [7:0] amt, input logic ci,
                             input logic [31:0] er, input logic ec, input int req);
    @(negedge clk);
    operand_i = op; type_i = ty; reg_mode_i = md; amt_i = amt; carry_i = ci;
    @(posedge clk);
    #1;
    checks++;
    if (result_o !== er || carry_o !== ec) begin
      errors++;
      $display("FAIL R%0d: op=%h ty=%0d md=%0d amt=%0d ci=%0d got res=%h c=%0d exp res=%h c=%0d",
               req, op, ty, md, amt, ci, result_o, carry_o, er, ec);
    end
  endtask

  localparam logic [31:0] OPS [4] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5A5_3C3C, 32'h0000_0000};
  localparam logic [7:0]  AMTS [6] = '{8'd0, 8'd1, 8'd31, 8'd32, 8'd33, 8'd255};

  initial begin
    logic [32:0] e;
    operand_i = '0; type_i = '0; reg_mode_i = 1'b0; amt_i = '0; carry_i = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // idle state: zero inputs give zero outputs (R1 zero-amount pass)
    apply_check('0, 2'd0, 1'b0, 8'd0, 1'b0, '0, 1'b0, 1);
    for (int i = 0; i < NV; i++)
      apply_check(VECS[i].op, VECS[i].ty, VECS[i].md, VECS[i].amt, VECS[i].ci,
                  VECS[i].res, VECS[i].co, int'(VECS[i].req));
    // boundary sweep against the reference model
    for (int o = 0; o < 4; o++)
      for (int t = 0; t < 4; t++)
        for (int m = 0; m < 2; m++)
          for (int a = 0; a < 6; a++)
            for (int c = 0; c < 2; c++) begin
              e = ref_shift(OPS[o], 2'(t), 1'(m), AMTS[a], 1'(c));
              apply_check(OPS[o], 2'(t), 1'(m), AMTS[a], 1'(c), e[32:1], e[0],
                          req_of(2'(t), 1'(m), AMTS[a]));
            end
    // R11: upper amount bits ignored in immediate form for every kind
    for (int t = 0; t < 4; t++) begin
      e = ref_shift(32'hC3C3_0F0F, 2'(t), 1'b0, 8'd5, 1'b1);
      apply_check(32'hC3C3_0F0F, 2'(t), 1'b0, 8'hE5, 1'b1, e[32:1], e[0], 11);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule